// File: doc/BRIEF.md
# PCI Type 0 Configuration Target

This block is the configuration-space responder of a single-function PCI device. It watches the shared bus for the start of a transaction. It claims a cycle when the cycle is a Type 0 configuration read or write addressed to this device. It then runs a fixed-length handshake with medium decode timing. Reads return one 32-bit word of the configuration header. Writes update the writable bits of that word, one byte lane at a time as the byte enables select them.

Every claimed cycle has the same shape. DEVSEL# appears two clocks after the address phase, and TRDY# one clock after that. When the initiator tries to continue past the first data phase, the block stops the burst by asserting STOP# together with TRDY#. While the `loading` input is high, the register defaults are still arriving from non-volatile storage after reset. During that time every claimed cycle ends with a retry: STOP# is asserted without TRDY#, and no data moves. After each claimed cycle the block drives the three control lines high for one clock and then releases them.

A new address phase is recognised from the falling edge of FRAME#. This works even when the address phase follows the last data phase of a transfer to another target with no idle clock in between.

Top module: `cfg_space_target`

## Requirements
- R1: A cycle is claimed only when IDSEL is high and C/BE#[3:0] is 1010 (read) or 1011 (write) in the address phase, with AD[1:0] = 00. AD[7:2] selects the word index. AD[31:8] have no effect on the decode. In all other cases DEVSEL# stays deasserted.
- R2: Counting the clock edge that samples the address phase as edge 0, DEVSEL# is still high after edge 0 and is low after edge 1.
- R3: TRDY# is low after edge 2 in every non-retry cycle, so the data transfer completes at edge 3 when IRDY# is low. During a read, AD carries the selected word while ad_oe is high.
- R4: A write changes only the byte lanes whose C/BE# bit is 0 in the data phase (lane n = AD[8n+7:8n]), and only the writable bits within them.
- R5: When FRAME# is still low at edge 2, STOP# is asserted together with TRDY#. If the transfer completes with FRAME# still low, the next clock shows STOP# low with TRDY# high until FRAME# is sampled high. Only the first word is written.
- R6: If `loading` is high in the address phase, the block gives a retry. After edge 2, STOP# and DEVSEL# are low and TRDY# is high, and no register is changed.
- R7: Register contents. Word 0 = {device ID, vendor ID}. Word 1 = command in bits [15:0], where only bits 0, 1, 2, 6 and 8 are writable; status bits [31:16] read 0x0080, so bit 23 (fast back-to-back capable) is always 1. Word 2 = {class code, revision}. Word 3 has bits [15:0] writable. Word 4 = I/O base: bits [31:5] writable, bit 0 reads 1. Word 5 = memory base: bits [31:5] writable. Word 15 = {max latency, min grant, interrupt pin = 0x01, interrupt line}, where only the interrupt line is writable. All other words read as zero, and writes to them are ignored.
- R8: In the clock after a claimed cycle ends, the control lines are driven (ctl_oe high) with DEVSEL#, TRDY# and STOP# all high. In the clock after that, ctl_oe is low.
- R9: An address phase that directly follows another target's final data phase, with FRAME# high for only that one clock, is decoded with the same R2/R3 timing.
- R10: During and after reset, DEVSEL#, TRDY# and STOP# read high, ctl_oe and ad_oe are low, and all writable bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loading | input | 1 | High while register defaults are still being loaded |
| idsel | input | 1 | Device select for configuration cycles |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| cbe_n | input | 4 | Command (address phase) / byte enables (data phase), active low |
| ad_in | input | 32 | Address/data bus as seen by the block |
| ad_out | output | 32 | Read data driven toward AD |
| ad_oe | output | 1 | Enable for ad_out onto AD |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low |
| ctl_oe | output | 1 | Enable for DEVSEL#, TRDY# and STOP# |

## Verification
In a burst attempt, the disconnect function and the data transfer function fall in the same cycle. STOP# is asserted in the same cycle as TRDY#, and the write commits on the edge where FRAME# is still low. The bench provokes this by holding FRAME# low through the data phase of a write. It checks STOP# and TRDY# together at the third clock and STOP# alone on the next clock. It then reads the word back to confirm that exactly one write took effect. A second overlap is a fast back-to-back address phase arriving right after a foreign data phase. It is provoked with no idle clock and judged on the same DEVSEL# and TRDY# timing as an isolated cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DEV,
    ST_XFER,
    ST_STOP,
    ST_TURN
  } tgt_state_e;

  localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;

  function automatic logic cmd_is_cfg(input logic [3:0] cmd);
    return (cmd == CMD_CFG_READ) || (cmd == CMD_CFG_WRITE);
  endfunction

  // expand active-low byte enables into a 32-bit lane mask
  function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{~be_n[b]}};
    return m;
  endfunction

  // new word value after a byte-enabled write restricted to writable bits
  function automatic logic [31:0] merge_write(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be_n,
                                              input logic [31:0] wmask);
    logic [31:0] m;
    m = lane_mask(be_n) & wmask;
    return (old_w & ~m) | (new_w & m);
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             frame_n,
  input  logic             idsel,
  input  logic             loading,
  input  logic [3:0]       cbe_n,
  input  logic [7:0]       ad_lo,
  output logic             addr_hit,
  output logic [IDX_W-1:0] idx_q,
  output logic             wr_q,
  output logic             load_q
);
  import cfg_pkg::*;

  logic frame_prev_n;
  logic frame_fall;

  assign frame_fall = frame_prev_n && !frame_n;
  assign addr_hit   = accept && frame_fall && idsel &&
                      cmd_is_cfg(cbe_n) && (ad_lo[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_prev_n <= 1'b1;
      idx_q        <= '0;
      wr_q         <= 1'b0;
      load_q       <= 1'b0;
    end else begin
      frame_prev_n <= frame_n;
      if (addr_hit) begin
        idx_q  <= ad_lo[2 +: IDX_W];
        wr_q   <= (cbe_n == CMD_CFG_WRITE);
        load_q <= loading;
      end
    end
  end

endmodule

// File: rtl/cfg_handshake.sv
module cfg_handshake (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_hit,
  input  logic               load_q,
  input  logic               frame_n,
  input  logic               irdy_n,
  output cfg_pkg::tgt_state_e state_q,
  output logic               accept,
  output logic               xfer_done,
  output logic               devsel_n,
  output logic               trdy_n,
  output logic               stop_n,
  output logic               ctl_oe
);
  import cfg_pkg::*;

  tgt_state_e state_d;
  logic       burst_q;

  assign accept    = (state_q == ST_IDLE) || (state_q == ST_TURN);
  assign xfer_done = (state_q == ST_XFER) && !irdy_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (addr_hit) state_d = ST_WAIT;
      ST_WAIT: state_d = ST_DEV;
      ST_DEV:  state_d = load_q ? ST_STOP : ST_XFER;
      ST_XFER: if (!irdy_n) state_d = frame_n ? ST_TURN : ST_STOP;
      ST_STOP: if (frame_n) state_d = ST_TURN;
      ST_TURN: state_d = addr_hit ? ST_WAIT : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DEV) burst_q <= !frame_n;
    end
  end

  assign ctl_oe   = (state_q == ST_DEV) || (state_q == ST_XFER) ||
                    (state_q == ST_STOP) || (state_q == ST_TURN);
  assign devsel_n = !((state_q == ST_DEV) || (state_q == ST_XFER) ||
                      (state_q == ST_STOP));
  assign trdy_n   = !(state_q == ST_XFER);
  assign stop_n   = !((state_q == ST_STOP) ||
                      ((state_q == ST_XFER) && burst_q));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int          N_DW       = 64,
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'h7A31,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h028000,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h18,
  parameter logic [7:0]  MAX_LAT    = 8'h38,
  parameter logic [15:0] CMD_WMASK  = 16'h0147,
  localparam int         IDX_W      = $clog2(N_DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       be_n,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  import cfg_pkg::*;

  function automatic logic [31:0] word_wmask(input int i);
    case (i)
      1:       return {16'h0000, CMD_WMASK};
      3:       return 32'h0000_FFFF;
      4, 5:    return 32'hFFFF_FFE0;
      15:      return 32'h0000_00FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] word_fixed(input int i);
    case (i)
      0:       return {DEVICE_ID, VENDOR_ID};
      1:       return 32'h0080_0000;
      2:       return {CLASS_CODE, REV_ID};
      4:       return 32'h0000_0001;
      15:      return {MAX_LAT, MIN_GNT, INT_PIN, 8'h00};
      default: return 32'h0;
    endcase
  endfunction

  logic [31:0] wmask_tbl [N_DW];
  logic [31:0] fixed_tbl [N_DW];
  logic [31:0] store_q   [N_DW];

  for (genvar g = 0; g < N_DW; g++) begin : g_tbl
    assign wmask_tbl[g] = word_wmask(g);
    assign fixed_tbl[g] = word_fixed(g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DW; i++) store_q[i] <= '0;
    end else if (wr_en) begin
      store_q[idx] <= merge_write(store_q[idx], wdata, be_n, wmask_tbl[idx]);
    end
  end

  assign rdata = (store_q[idx] & wmask_tbl[idx]) | fixed_tbl[idx];

endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target #(
  parameter int          N_DW       = 64,
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'h7A31,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h028000,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h18,
  parameter logic [7:0]  MAX_LAT    = 8'h38
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loading,
  input  logic        idsel,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        ctl_oe
);
  import cfg_pkg::*;

  localparam int IDX_W = $clog2(N_DW);

  tgt_state_e       state_q;
  logic             accept;
  logic             addr_hit;
  logic             xfer_done;
  logic             wr_commit;
  logic             wr_q;
  logic             load_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      rd_word;

  cfg_addr_decode #(.IDX_W(IDX_W)) i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .frame_n  (frame_n),
    .idsel    (idsel),
    .loading  (loading),
    .cbe_n    (cbe_n),
    .ad_lo    (ad_in[7:0]),
    .addr_hit (addr_hit),
    .idx_q    (idx_q),
    .wr_q     (wr_q),
    .load_q   (load_q)
  );

  cfg_handshake i_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_hit  (addr_hit),
    .load_q    (load_q),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .state_q   (state_q),
    .accept    (accept),
    .xfer_done (xfer_done),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .ctl_oe    (ctl_oe)
  );

  assign wr_commit = xfer_done && wr_q;

  cfg_regfile #(
    .N_DW       (N_DW),
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REV_ID     (REV_ID),
    .CLASS_CODE (CLASS_CODE),
    .INT_PIN    (INT_PIN),
    .MIN_GNT    (MIN_GNT),
    .MAX_LAT    (MAX_LAT)
  ) i_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_commit),
    .idx   (idx_q),
    .be_n  (cbe_n),
    .wdata (ad_in),
    .rdata (rd_word)
  );

  assign ad_oe  = (state_q == ST_XFER) && !wr_q;
  assign ad_out = ad_oe ? rd_word : 32'h0;

endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loading,
  input logic             frame_n,
  input logic             irdy_n,
  input logic             devsel_n,
  input logic             trdy_n,
  input logic             stop_n,
  input logic             ctl_oe,
  input logic             ad_oe,
  input logic [31:0]      ad_out,
  input logic             addr_hit,
  input logic             wr_commit,
  input logic [IDX_W-1:0] rd_idx
);

  p_devsel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> devsel_n);

  p_devsel_medium_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> ##2 !devsel_n);

  p_trdy_third_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && !loading) |-> ##3 !trdy_n);

  p_write_on_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (!trdy_n && !irdy_n && !devsel_n));

  p_burst_disc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && !frame_n) |=> (!stop_n && trdy_n && !devsel_n));

  p_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && loading) |-> ##3 (!stop_n && trdy_n && !devsel_n));

  p_fbb_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && rd_idx == IDX_W'(1)) |-> ad_out[23]);

  p_turn_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |-> (ctl_oe && trdy_n && stop_n));

  p_turn_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |=> !ctl_oe);

endmodule

bind cfg_space_target cfg_space_checker #(.IDX_W(IDX_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loading   (loading),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .devsel_n  (devsel_n),
  .trdy_n    (trdy_n),
  .stop_n    (stop_n),
  .ctl_oe    (ctl_oe),
  .ad_oe     (ad_oe),
  .ad_out    (ad_out),
  .addr_hit  (addr_hit),
  .wr_commit (wr_commit),
  .rd_idx    (idx_q)
);

// File: tb/test_cfg_space_target.sv
`timescale 1ns/1ps
module test_cfg_space_target;

  localparam logic [3:0] RD = 4'b1010;
  localparam logic [3:0] WR = 4'b1011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loading = 1'b0;
  logic        idsel = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] sb_q[$];

  always #2.5 clk = ~clk;

  cfg_space_target #(
    .VENDOR_ID(16'h1D0F), .DEVICE_ID(16'h7A31), .REV_ID(8'h03),
    .CLASS_CODE(24'h028000), .INT_PIN(8'h01), .MIN_GNT(8'h18), .MAX_LAT(8'h38)
  ) i_cfg_space_target (
    .clk(clk), .rst_n(rst_n), .loading(loading), .idsel(idsel),
    .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .ctl_oe(ctl_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: every completed read transfer pops one expected word
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !trdy_n && !irdy_n && ad_oe) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 unexpected read", ad_out, 32'h0);
        end else begin
          logic [31:0] e;
          e = sb_q.pop_front();
          chk(ad_out == e, "R3/R7 read data", ad_out, e);
        end
      end
    end
  end

  task automatic cfg_cycle(input logic sel, input logic [3:0] cmd,
                           input logic [31:0] addr, input logic [3:0] be_n,
                           input logic [31:0] wdata, input logic burst,
                           input logic b2b, input logic claim,
                           input logic retry, input logic [31:0] exp_rd);
    if (b2b) begin
      tick; frame_n = 1'b0; idsel = 1'b0; cbe_n = 4'b0110;
      ad_in = 32'h5555_0000; irdy_n = 1'b1;
      tick; frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0;
    end
    tick; frame_n = 1'b0; idsel = sel; cbe_n = cmd; ad_in = addr;
    if (!b2b) irdy_n = 1'b1;
    if (claim && !retry && cmd == RD) sb_q.push_back(exp_rd);
    tick;
    idsel = 1'b0; cbe_n = be_n; ad_in = (cmd == WR) ? wdata : 32'h0;
    irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1;
    if (!claim) begin
      for (int n = 0; n < 4; n++) begin
        @(negedge clk);
        chk(devsel_n && !ctl_oe, "R1 not claimed", {31'h0, devsel_n}, 32'h1);
      end
      tick; frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0;
      return;
    end
    @(negedge clk);
    chk(devsel_n == 1'b1, "R2 devsel after edge0", {31'h0, devsel_n}, 32'h1);
    @(negedge clk);
    chk(!devsel_n && trdy_n, "R2 devsel after edge1",
        {30'h0, devsel_n, trdy_n}, 32'h1);
    @(negedge clk);
    if (retry) begin
      chk(!stop_n && trdy_n && !devsel_n, "R6 retry response",
          {29'h0, devsel_n, trdy_n, stop_n}, 32'h2);
    end else begin
      chk(!trdy_n, "R3 trdy after edge2", {31'h0, trdy_n}, 32'h0);
      chk(stop_n == !burst, "R5 stop with trdy", {31'h0, stop_n},
          {31'h0, !burst});
    end
    if (burst && !retry) begin
      tick; frame_n = 1'b1;
      @(negedge clk);
      chk(!stop_n && trdy_n && !devsel_n, "R5 disconnect hold",
          {29'h0, devsel_n, trdy_n, stop_n}, 32'h2);
    end
    tick; irdy_n = 1'b1; frame_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
    @(negedge clk);
    chk(ctl_oe && devsel_n && trdy_n && stop_n, "R8 turnaround drive",
        {28'h0, ctl_oe, devsel_n, trdy_n, stop_n}, 32'hF);
    @(negedge clk);
    chk(!ctl_oe, "R8 release", {31'h0, ctl_oe}, 32'h0);
  endtask

  task automatic rd(input logic [5:0] idx, input logic [31:0] exp);
    cfg_cycle(1'b1, RD, {24'h0, idx, 2'b00}, 4'h0, '0, 1'b0, 1'b0, 1'b1, 1'b0, exp);
  endtask

  task automatic wr(input logic [5:0] idx, input logic [3:0] be_n,
                    input logic [31:0] d);
    cfg_cycle(1'b1, WR, {24'h0, idx, 2'b00}, be_n, d, 1'b0, 1'b0, 1'b1, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe, "R10 in reset",
        {27'h0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, 32'h1C);
    rst_n = 1'b1;
    repeat (2) tick;
    chk(devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe, "R10 after reset",
        {27'h0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, 32'h1C);

    // R6 retry while loading: write must not land
    loading = 1'b1;
    cfg_cycle(1'b1, WR, {24'h0, 6'd15, 2'b00}, 4'h0, 32'h0000_00AA,
              1'b0, 1'b0, 1'b1, 1'b1, '0);
    loading = 1'b0;
    rd(6'd15, 32'h3818_0100);                 // R6 no effect, R7 reset value

    // R1 upper address bits ignored
    cfg_cycle(1'b1, RD, 32'hABCD_E500, 4'h0, '0, 1'b0, 1'b0, 1'b1, 1'b0,
              32'h7A31_1D0F);
    rd(6'd1, 32'h0080_0000);                  // R7 fast back-to-back bit
    rd(6'd2, 32'h0280_0003);                  // R7 class/revision
    wr(6'd1, 4'h0, 32'hFFFF_FFFF);
    rd(6'd1, 32'h0080_0147);                  // R7 command mask, status fixed
    wr(6'd4, 4'h0, 32'h1234_5678);
    rd(6'd4, 32'h1234_5661);                  // R7 I/O base bits
    wr(6'd3, 4'b1110, 32'hAABB_CCDD);
    wr(6'd3, 4'b1101, 32'h1122_3344);
    rd(6'd3, 32'h0000_33DD);                  // R4 single byte lanes
    wr(6'd5, 4'b0011, 32'hDEAD_BEEF);
    rd(6'd5, 32'hDEAD_0000);                  // R4 upper half lanes
    wr(6'd9, 4'h0, 32'hFFFF_FFFF);
    rd(6'd9, 32'h0);                          // R7 unimplemented word

    // R1 cycles that must not be claimed
    cfg_cycle(1'b1, RD, 32'h0000_0001, 4'h0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    cfg_cycle(1'b0, RD, 32'h0000_0000, 4'h0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    cfg_cycle(1'b1, 4'b0110, 32'h0000_0000, 4'h0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0);

    // R5 burst attempt: disconnect, one word written
    cfg_cycle(1'b1, WR, {24'h0, 6'd15, 2'b00}, 4'h0, 32'hFFFF_FFAB,
              1'b1, 1'b0, 1'b1, 1'b0, '0);
    rd(6'd15, 32'h3818_01AB);

    // R9 fast back-to-back after another target's data phase
    cfg_cycle(1'b1, RD, {24'h0, 6'd0, 2'b00}, 4'h0, '0, 1'b0, 1'b1, 1'b1, 1'b0,
              32'h7A31_1D0F);

    repeat (3) tick;
    chk(sb_q.size() == 0, "R3 all reads seen", sb_q.size(), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule